// File: doc/BRIEF.md
# Round-Trip Latency Cycle Timer

This block measures how long a frame takes to travel out of a MAC's transmit stream and back in on its receive stream, counted in transmit-clock cycles. It watches the valid and end-of-frame flags of the transmit stream in the transmit clock domain and the valid flag of the receive stream in an unrelated receive clock domain. Counting starts on the first transmit beat of a frame and stops when the first receive beat is seen. The stop event is carried into the transmit domain through a two-flop synchronizer. That adds a bias of two to three transmit cycles, which software removes by subtracting two.

A one-cycle new-test pulse in the transmit domain clears the count and starts a clear handshake with the receive domain. That handshake resets the receive-side stop flag. Once both sides agree the flag is low, the timer arms and waits for the next frame start. The held count stays on the output port for a register read until the next new-test pulse.

The controller has six states. IDLE is the state after reset. CLEAR holds the clear request. DRAIN waits for the acknowledge and the stop flag to fall. ARMED waits for a frame start. RUN counts. HOLD keeps the result. The transitions are:
- IDLE stays in IDLE.
- CLEAR goes to DRAIN when the acknowledge is seen.
- DRAIN goes to ARMED once the acknowledge and the synchronized stop are both low.
- ARMED goes to RUN on a first beat.
- RUN goes to HOLD when the synchronized stop is seen.
- HOLD stays in HOLD.
- A new-test pulse sends any state to CLEAR.

Top module: `rtt_latency_timer`

## Requirements
- R1: After reset the count reads 0 and stays 0, whatever the streams do, until a new-test pulse has armed the timer.
- R2: While armed, a transmit beat (tx_valid=1) seen while the start-of-frame flag is high moves the timer to RUN with the count still 0.
- R3: In RUN the count rises by exactly one on every transmit clock edge at which the synchronized stop is low.
- R4: The first receive beat (rx_valid=1) passes through two receive-to-transmit flops. With both clocks at the same frequency and receive edges 2 ns after transmit edges, a receive beat applied at transmit edge e stops counting so that the final count equals (e+2) minus the start edge.
- R5: Once stopped, the count holds its value against any further transmit or receive beats until the next new-test pulse.
- R6: A new-test pulse (new_test=1 for one cycle) forces the count to 0 at the next edge. Transmit beats during the clear handshake do not start the timer.
- R7: The start-of-frame flag is high out of reset. It drops after a beat with tx_last=0 and rises after a beat with tx_last=1, so arming in the middle of a frame delays the start to the first beat of the following frame.
- R8: Only the first receive beat after the receive-side flag is cleared acts as a stop. The flag stays high until a new-test clear reaches the receive domain.
- R9: A new-test pulse during RUN aborts the measurement and returns the count to 0.
- R10: The count is a full CNT_W-bit (default 32) value, and counts above 255 read back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit-domain clock; all counting happens here |
| tx_rst_n | input | 1 | Active-low asynchronous reset, transmit domain |
| rx_clk | input | 1 | Receive-domain clock |
| rx_rst_n | input | 1 | Active-low asynchronous reset, receive domain |
| new_test | input | 1 | One-cycle pulse (tx_clk) that clears and re-arms the timer |
| tx_valid | input | 1 | Transmit stream beat valid |
| tx_last | input | 1 | Transmit stream end-of-frame marker |
| rx_valid | input | 1 | Receive stream beat valid (rx_clk) |
| latency_count | output | CNT_W | Measured round-trip cycle count, held after stop |

## Verification
A controller stuck in the wrong state shows up on latency_count within one transmit cycle. A missed start leaves the count at zero when it should step. A missed stop keeps it climbing past the value predicted from the receive-beat edge. A stop flag that is not cleared ends the next measurement at once with a tiny count. A wrong start-of-frame flag moves the start by one frame, so every later count is off by several cycles. The bench compares the count with a behavioural model on every transmit edge, so any such fault is reported in the cycle it first appears.

// File: rtl/rtt_pkg.sv
`timescale 1ns/1ps
package rtt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_DRAIN = 3'd2,
        ST_ARMED = 3'd3,
        ST_RUN   = 3'd4,
        ST_HOLD  = 3'd5
    } rtt_state_e;

    localparam int unsigned RTT_DEF_SYNC_STAGES = 2;
    localparam int unsigned RTT_DEF_CNT_W       = 32;

endpackage

// File: rtl/rtt_sync_bits.sv
`timescale 1ns/1ps
module rtt_sync_bits #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/rtt_sof_scan.sv
`timescale 1ns/1ps
module rtt_sof_scan (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    input  logic tx_last,
    output logic sof,
    output logic first_beat
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sof <= 1'b1;
        end else if (tx_valid) begin
            sof <= tx_last;
        end
    end

    assign first_beat = tx_valid & sof;

    AST_SOF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_last) |=> !sof);                              // R7
    AST_SOF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last) |=> sof);                                // R7
    AST_SOF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> $stable(sof));                                   // R7

endmodule

// File: rtl/rtt_rx_stop.sv
`timescale 1ns/1ps
module rtt_rx_stop (
    input  logic rx_clk,
    input  logic rx_rst_n,
    input  logic rx_valid,
    input  logic clr_rx,
    output logic stop_flag
);

    always_ff @(posedge rx_clk or negedge rx_rst_n) begin
        if (!rx_rst_n) begin
            stop_flag <= 1'b0;
        end else if (clr_rx) begin
            stop_flag <= 1'b0;
        end else if (rx_valid) begin
            stop_flag <= 1'b1;
        end
    end

    AST_STOP_STICKY: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        (stop_flag && !clr_rx) |=> stop_flag);                          // R8
    AST_STOP_CLEARED: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        clr_rx |=> !stop_flag);                                         // R8

endmodule

// File: rtl/rtt_ctrl_fsm.sv
`timescale 1ns/1ps
module rtt_ctrl_fsm
    import rtt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             new_test,
    input  logic             first_beat,
    input  logic             stop_seen,
    input  logic             ack_seen,
    output logic             clr_req,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    rtt_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = ST_IDLE;
            ST_CLEAR: if (ack_seen) nxt = ST_DRAIN;
            ST_DRAIN: if (!ack_seen && !stop_seen) nxt = ST_ARMED;
            ST_ARMED: if (first_beat) nxt = ST_RUN;
            ST_RUN:   if (stop_seen) nxt = ST_HOLD;
            ST_HOLD:  nxt = ST_HOLD;
            default:  nxt = ST_IDLE;
        endcase
        if (new_test) nxt = ST_CLEAR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            clr_req <= 1'b0;
        end else begin
            if (new_test) begin
                count <= '0;
            end else if (state == ST_RUN && !stop_seen) begin
                count <= count + CNT_ONE;
            end
            if (new_test) begin
                clr_req <= 1'b1;
            end else if (state == ST_CLEAR && ack_seen) begin
                clr_req <= 1'b0;
            end
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (count == '0));                            // R1
    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && first_beat && !new_test) |=> (state == ST_RUN && count == '0)); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !stop_seen && !new_test) |=> (count == $past(count) + CNT_ONE)); // R3
    AST_RUN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_seen && !new_test) |=> (state == ST_HOLD)); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !new_test) |=> $stable(count));              // R5
    AST_CLEAR_ON_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        new_test |=> (count == '0 && state == ST_CLEAR));                 // R6

endmodule

// File: rtl/rtt_latency_timer.sv
`timescale 1ns/1ps
module rtt_latency_timer
    import rtt_pkg::*;
#(
    parameter int unsigned CNT_W       = RTT_DEF_CNT_W,
    parameter int unsigned SYNC_STAGES = RTT_DEF_SYNC_STAGES
) (
    input  logic             tx_clk,
    input  logic             tx_rst_n,
    input  logic             rx_clk,
    input  logic             rx_rst_n,
    input  logic             new_test,
    input  logic             tx_valid,
    input  logic             tx_last,
    input  logic             rx_valid,
    output logic [CNT_W-1:0] latency_count
);

    logic sof;
    logic first_beat;
    logic clr_req;
    logic clr_rx;
    logic stop_flag;
    logic stop_seen;
    logic ack_seen;

    rtt_sof_scan u_sof (
        .clk        (tx_clk),
        .rst_n      (tx_rst_n),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last),
        .sof        (sof),
        .first_beat (first_beat)
    );

    rtt_sync_bits #(.STAGES(SYNC_STAGES), .W(1)) u_clr_to_rx (
        .clk   (rx_clk),
        .rst_n (rx_rst_n),
        .d     (clr_req),
        .q     (clr_rx)
    );

    rtt_rx_stop u_rx_stop (
        .rx_clk    (rx_clk),
        .rx_rst_n  (rx_rst_n),
        .rx_valid  (rx_valid),
        .clr_rx    (clr_rx),
        .stop_flag (stop_flag)
    );

    rtt_sync_bits #(.STAGES(SYNC_STAGES), .W(1)) u_stop_to_tx (
        .clk   (tx_clk),
        .rst_n (tx_rst_n),
        .d     (stop_flag),
        .q     (stop_seen)
    );

    rtt_sync_bits #(.STAGES(SYNC_STAGES), .W(1)) u_ack_to_tx (
        .clk   (tx_clk),
        .rst_n (tx_rst_n),
        .d     (clr_rx),
        .q     (ack_seen)
    );

    rtt_ctrl_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (tx_clk),
        .rst_n      (tx_rst_n),
        .new_test   (new_test),
        .first_beat (first_beat),
        .stop_seen  (stop_seen),
        .ack_seen   (ack_seen),
        .clr_req    (clr_req),
        .count      (latency_count)
    );

    AST_HOLD_NO_ZERO_JUMP: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        (!new_test && latency_count != '0) |=> (latency_count != '0));    // R5

endmodule

// File: tb/rtt_latency_timer_tb_top.sv
`timescale 1ns/1ps
module rtt_latency_timer_tb_top;

    logic        tx_clk   = 1'b0;
    logic        rx_clk   = 1'b0;
    logic        tx_rst_n = 1'b0;
    logic        rx_rst_n = 1'b0;
    logic        new_test = 1'b0;
    logic        tx_valid = 1'b0;
    logic        tx_last  = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] latency_count;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    int          edge_no      = 0;
    bit          m_sof        = 1'b1;
    int          m_phase      = 0;   // 0 idle, 1 clearing, 2 armed, 3 running, 4 holding
    int          m_clear_edge = 0;
    bit          m_rxflag     = 1'b0;
    int          m_stop_edge  = -1;
    logic [31:0] m_cnt        = '0;

    always #2.5 tx_clk = ~tx_clk;
    initial begin
        #2;
        forever #2.5 rx_clk = ~rx_clk;
    end

    rtt_latency_timer dut_i (
        .tx_clk        (tx_clk),
        .tx_rst_n      (tx_rst_n),
        .rx_clk        (rx_clk),
        .rx_rst_n      (rx_rst_n),
        .new_test      (new_test),
        .tx_valid      (tx_valid),
        .tx_last       (tx_last),
        .rx_valid      (rx_valid),
        .latency_count (latency_count)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic check_now();
        n_chk++;
        if (latency_count !== m_cnt) begin
            n_err++;
            $display("FAIL %s: latency_count=%0d expected %0d (edge %0d)",
                     cur_req, latency_count, m_cnt, edge_no);
        end
    endtask

    task automatic model_edge(input bit tv, input bit tl, input bit rv, input bit nt);
        edge_no++;
        if (nt) begin
            m_cnt        = '0;
            m_phase      = 1;
            m_clear_edge = edge_no;
            m_rxflag     = 1'b0;
            m_stop_edge  = -1;
        end else begin
            case (m_phase)
                1: if (edge_no - m_clear_edge >= 15) m_phase = 2;
                2: if (tv && m_sof) m_phase = 3;
                3: begin
                    if (m_stop_edge >= 0 && edge_no > m_stop_edge) m_phase = 4;
                    else m_cnt = m_cnt + 32'd1;
                end
                default: ;
            endcase
            if (rv && !m_rxflag) begin
                m_rxflag = 1'b1;
                if (m_phase == 3) m_stop_edge = edge_no + 2;
            end
        end
        if (tv) m_sof = tl;
    endtask

    task automatic cyc(input bit tv, input bit tl, input bit rv, input bit nt);
        tx_valid = tv;
        tx_last  = tl;
        rx_valid = rv;
        new_test = nt;
        @(posedge tx_clk);
        model_edge(tv, tl, rv, nt);
        @(negedge tx_clk);
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        rx_valid = 1'b0;
        new_test = 1'b0;
        check_now();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic arm();
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        idle(20);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, got %0d expected 0 hangs", n_chk);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge tx_clk);
        tx_rst_n = 1'b1;
        rx_rst_n = 1'b1;

        // R1: reset value and no counting before arming
        cur_req = "R1";
        check_now();
        idle(2);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        idle(3);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        idle(6);

        // R6: clear, with transmit beats during the handshake ignored
        cur_req = "R6";
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        idle(19);

        // R2, R4: single-beat frame, stop six cycles later
        cur_req = "R2";
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        cur_req = "R4";
        idle(5);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        idle(6);

        // R5, R8: later beats on both streams leave the held count alone
        cur_req = "R5";
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        cur_req = "R8";
        cyc(1'b1, 1'b1, 1'b1, 1'b0);
        idle(8);

        // R3: multi-beat frame, receive beat arrives mid-frame
        cur_req = "R6";
        arm();
        cur_req = "R3";
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1, 1'b0);
        idle(8);

        // R7: armed mid-frame, start waits for the next frame
        cur_req = "R7";
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        arm();
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        idle(3);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        idle(1);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        idle(8);

        // R9: abort during a run
        cur_req = "R6";
        arm();
        cur_req = "R9";
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        idle(4);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        idle(20);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        idle(9);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        idle(8);

        // R10: count beyond eight bits
        cur_req = "R6";
        arm();
        cur_req = "R10";
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        idle(299);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        idle(8);
        n_chk++;
        if (latency_count !== 32'd302) begin
            n_err++;
            $display("FAIL R10: latency_count=%0d expected %0d", latency_count, 302);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule